// File: doc/BRIEF.md
# Unaligned Data Access Splitter

This block sits between a processor's load/store path and a 32-bit external bus. It accepts one data access at a time: a byte, a halfword or a word, at any byte address. It turns that access into the bus cycles the bus can carry, where every bus cycle is naturally aligned to its own size.

An unaligned access is split in a fixed, address-dependent pattern. For example, a word at an odd address becomes a byte cycle, then a halfword cycle, then a byte cycle. For writes, the block places each data byte on the lane that matches its address and marks those lanes with byte enables. For reads, it collects the bytes returned on the lanes into one little-endian result.

While a split is in progress, a multi-cycle flag stays high so that a bus arbiter can keep the bus locked. A new request is taken only when the block is idle.

Top module: `misaligned_splitter`

## Requirements
- R1: An aligned halfword (address bit 0 clear) or aligned word (low two address bits 00) completes in a single bus cycle of its own size at the request address. Every bus cycle issued is naturally aligned: word cycles have address bits [1:0] = 00 and halfword cycles have address bit 0 = 0.
- R2: A halfword request with address bit 0 set produces exactly two byte cycles, at A and then at A+1.
- R3: A word request with address bit 0 set produces exactly three cycles in this order: a byte at A, a halfword at A+1, a byte at A+3.
- R4: A word request whose low address bits are 10 produces exactly two halfword cycles, at A and then at A+2.
- R5: A byte request at any address produces exactly one byte cycle at that address. Size codes on req_size and bus_size are 0 = byte, 1 = halfword and 2 = word; code 3 is handled as a word.
- R6: On a read, rd_data holds the operand in little-endian order. Byte i, at bits [8i+7:8i], comes from address A+i. Bytes above the request size are zero.
- R7: On a write cycle to bus address B, with operand bytes k to k+n-1 carried, operand byte k+j appears on lane (B[1:0]+j), at bits [8L+7:8L] of bus_wdata. bus_be bit L is set for exactly those lanes, so that memory receives exactly the request's bytes.
- R8: multi is high from the first cycle of a split until the bus_ack of its last cycle. It is low throughout single-cycle accesses and while idle.
- R9: rd_valid is a one-clock pulse in the cycle after the bus_ack of a read's last bus cycle. It is never raised for writes.
- R10: req_ready is low while a sequence is in progress, and an accepted request drives bus_valid in the next cycle. bus_valid, bus_addr and bus_size hold steady until bus_ack.
- R11: After a synchronous active-low reset, req_ready is high and bus_valid, multi and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Write operand, least significant byte first in memory |
| req_ready | output | 1 | Block idle, request will be taken |
| bus_valid | output | 1 | Bus cycle requested |
| bus_write | output | 1 | Direction of the bus cycle |
| bus_addr | output | ADDR_W | Byte address of the bus cycle |
| bus_size | output | 2 | Size code of the bus cycle |
| bus_be | output | 4 | Active byte lanes of the cycle |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_ack | input | 1 | Bus cycle completes at this clock edge |
| bus_rdata | input | 32 | Read data, lane-positioned |
| multi | output | 1 | Split sequence in progress |
| rd_valid | output | 1 | Read result valid pulse |
| rd_data | output | 32 | Assembled read result |

## Verification
Every size is driven at every one of the four address offsets, both as a read and as a write. These directed passes tell the single-cycle, byte-byte, halfword-halfword and byte-halfword-byte patterns apart by the cycle count, order and size of the cycles issued. A long random run then mixes sizes, addresses, directions and bus wait states from a fixed seed. Reads are compared with a byte-array memory model, which exposes wrong lane-to-byte mapping and stale upper bytes. Writes go through the same byte array, so a steering or byte-enable error shows up as a corrupted or missing memory byte.

// File: rtl/splitter_pkg.sv
// Shared types for the unaligned access splitter.
// Assumes a 32-bit bus with four byte lanes and little-endian byte order.
package splitter_pkg;

    localparam int LANES = 4;
    localparam int DW    = 8 * LANES;

    // Size code carried on request and bus; code 3 is handled as a word.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    // One planned bus cycle: its size, the operand byte it starts at, and
    // whether it is the final cycle of the sequence.
    typedef struct packed {
        size_e      csize;
        logic [1:0] offset;
        logic       last;
    } cycle_t;

    // Number of bytes a cycle of the given size transfers.
    function automatic logic [2:0] size_bytes(input size_e s);
        case (s)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/split_planner.sv
// Decomposition table for one access.
// What it does: given the request size, the low two address bits and the
// index of the cycle in progress, it names that cycle's size, its starting
// operand byte and whether it is the last one. It also reports the total
// number of cycles.
// Assumes: step never exceeds the cycle count minus one (the top enforces this).
module split_planner
    import splitter_pkg::*;
(
    input  size_e      op_size,
    input  logic [1:0] a_lo,
    input  logic [1:0] step,
    output cycle_t     cyc,
    output logic [1:0] n_cycles
);

    // Select the cycle pattern from size and alignment.
    always_comb begin
        cyc      = '{csize: SZ_BYTE, offset: 2'd0, last: 1'b1};
        n_cycles = 2'd1;
        case (op_size)
            SZ_BYTE: begin
                cyc.csize = SZ_BYTE;
            end
            SZ_HALF: begin
                if (a_lo[0]) begin
                    n_cycles   = 2'd2;
                    cyc.offset = (step == 2'd1) ? 2'd1 : 2'd0;
                    cyc.last   = (step == 2'd1);
                end else begin
                    cyc.csize = SZ_HALF;
                end
            end
            default: begin
                if (a_lo[0]) begin
                    n_cycles = 2'd3;
                    case (step)
                        2'd0:    cyc = '{csize: SZ_BYTE, offset: 2'd0, last: 1'b0};
                        2'd1:    cyc = '{csize: SZ_HALF, offset: 2'd1, last: 1'b0};
                        default: cyc = '{csize: SZ_BYTE, offset: 2'd3, last: 1'b1};
                    endcase
                end else if (a_lo[1]) begin
                    n_cycles   = 2'd2;
                    cyc.csize  = SZ_HALF;
                    cyc.offset = (step == 2'd1) ? 2'd2 : 2'd0;
                    cyc.last   = (step == 2'd1);
                end else begin
                    cyc.csize = SZ_WORD;
                end
            end
        endcase
    end

endmodule

// File: rtl/lane_steer.sv
// Write-side lane steering.
// What it does: for the current bus cycle it marks the active byte lanes and
// places each operand byte on the lane that matches its address.
// Assumes: the cycle is naturally aligned, so lane plus byte count never
// exceeds the lane count.
module lane_steer
    import splitter_pkg::*;
(
    input  size_e          csize,
    input  logic [1:0]     lane,
    input  logic [1:0]     offset,
    input  logic [DW-1:0]  op_wdata,
    output logic [LANES-1:0] be,
    output logic [DW-1:0]  wdata
);

    logic [2:0] nb;
    logic [1:0] idx;

    assign nb = size_bytes(csize);

    // Per lane: is it inside the cycle window, and which operand byte feeds it.
    always_comb begin
        be    = '0;
        wdata = '0;
        idx   = 2'd0;
        for (int l = 0; l < LANES; l++) begin
            be[l] = (3'(l) >= {1'b0, lane}) && (3'(l) < ({1'b0, lane} + nb));
            idx   = offset + 2'(l) - lane;
            if (be[l]) begin
                wdata[8*l +: 8] = op_wdata[8*idx +: 8];
            end
        end
    end

endmodule

// File: rtl/read_assembler.sv
// Read-side byte collection.
// What it does: on each acknowledged bus cycle it copies the active lanes
// into their little-endian positions of an accumulator. The accumulator is
// cleared when a new request is taken.
// Assumes: be marks exactly the lanes of the current cycle.
module read_assembler
    import splitter_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             capture,
    input  logic [LANES-1:0] be,
    input  logic [1:0]       lane,
    input  logic [1:0]       offset,
    input  logic [DW-1:0]    bus_rdata,
    output logic [DW-1:0]    acc
);

    logic [DW-1:0] acc_next;
    logic [1:0]    idx;

    // Merge the active lanes of this cycle into the result.
    always_comb begin
        acc_next = acc;
        idx      = 2'd0;
        for (int l = 0; l < LANES; l++) begin
            idx = offset + 2'(l) - lane;
            if (be[l]) begin
                acc_next[8*idx +: 8] = bus_rdata[8*l +: 8];
            end
        end
    end

    // Hold the accumulator; a clear wins over a capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
        end else if (capture) begin
            acc <= acc_next;
        end
    end

    // A fresh request starts from an empty result, so narrower reads return zero upper bytes.
    assert_clear_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0));

endmodule

// File: rtl/misaligned_splitter.sv
// Unaligned access splitter, top level.
// What it does: it takes one byte, halfword or word access at any address and
// issues the aligned bus cycles that complete it. It then returns the
// assembled read data or writes the steered bytes.
// Assumes: bus_ack is only meaningful while bus_valid is high, and the bus
// presents read data on the lanes of the addressed bytes.
module misaligned_splitter
    import splitter_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [3:0]        bus_be,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata,
    output logic              multi,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);

    logic              busy;
    size_e             op_size;
    logic              op_write;
    logic [ADDR_W-1:0] op_addr;
    logic [DW-1:0]     op_wdata;
    logic [1:0]        step;
    logic              rd_pulse;
    cycle_t            cyc;
    logic [1:0]        n_cycles;
    logic              accept;
    logic              done;

    assign accept = req_valid && !busy;
    assign done   = busy && bus_ack && cyc.last;

    split_planner u_plan (
        .op_size  (op_size),
        .a_lo     (op_addr[1:0]),
        .step     (step),
        .cyc      (cyc),
        .n_cycles (n_cycles)
    );

    // Bus cycle address: request address advanced by the consumed bytes.
    assign bus_addr  = op_addr + ADDR_W'(cyc.offset);
    assign bus_valid = busy;
    assign bus_write = op_write;
    assign bus_size  = cyc.csize;
    assign req_ready = !busy;
    assign multi     = busy && (n_cycles != 2'd1);
    assign rd_valid  = rd_pulse;

    lane_steer u_steer (
        .csize    (cyc.csize),
        .lane     (bus_addr[1:0]),
        .offset   (cyc.offset),
        .op_wdata (op_wdata),
        .be       (bus_be),
        .wdata    (bus_wdata)
    );

    read_assembler u_rasm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .capture   (busy && bus_ack && !op_write),
        .be        (bus_be),
        .lane      (bus_addr[1:0]),
        .offset    (cyc.offset),
        .bus_rdata (bus_rdata),
        .acc       (rd_data)
    );

    // Latch the request when idle; advance or finish the sequence on each ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            op_size  <= SZ_BYTE;
            op_write <= 1'b0;
            op_addr  <= '0;
            op_wdata <= '0;
            step     <= 2'd0;
        end else if (accept) begin
            busy     <= 1'b1;
            op_size  <= size_e'(req_size);
            op_write <= req_write;
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
            step     <= 2'd0;
        end else if (busy && bus_ack) begin
            if (cyc.last) begin
                busy <= 1'b0;
                step <= 2'd0;
            end else begin
                step <= step + 2'd1;
            end
        end
    end

    // One-clock read completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pulse <= 1'b0;
        end else begin
            rd_pulse <= done && !op_write;
        end
    end

    // Every issued word cycle is word aligned.
    assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_size == 2'd2) |-> (bus_addr[1:0] == 2'b00));

    // Every issued halfword cycle is halfword aligned.
    assert_half_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_size == 2'd1) |-> (bus_addr[0] == 1'b0));

    // Byte enables count matches the cycle size.
    assert_be_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> ($countones(bus_be) == ((bus_size == 2'd0) ? 1 :
                                              (bus_size == 2'd1) ? 2 : 4)));

    // The lock flag only appears alongside an open bus cycle.
    assert_multi_in_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        multi |-> bus_valid);

    // The read result pulse lasts a single clock.
    assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // An accepted request opens a bus cycle at its own address next clock.
    assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_valid && bus_addr == $past(req_addr)));

    // A cycle waiting for ack keeps its address and size.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_size)));

endmodule

// File: tb/misaligned_splitter_tb.sv
// Bench for the unaligned access splitter: directed sweep of all sizes at
// all offsets, then fixed-seed random accesses against a byte-array model.
module misaligned_splitter_tb;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_write;
    logic [1:0]    req_size;
    logic [AW-1:0] req_addr;
    logic [31:0]   req_wdata;
    logic          req_ready, bus_valid, bus_write;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [3:0]    bus_be;
    logic [31:0]   bus_wdata;
    logic          bus_ack;
    logic [31:0]   bus_rdata;
    logic          multi, rd_valid;
    logic [31:0]   rd_data;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] mem  [0:63];   // bus-side memory
    logic [7:0] refm [0:63];   // expected memory contents

    int         exp_n;
    int         exp_off [0:2];
    logic [1:0] exp_sz  [0:2];
    bit         exp_multi = 1'b0;
    int         obs_cnt;
    logic [AW-1:0] obs_addr [0:3];
    logic [1:0]    obs_sz   [0:3];

    always #4 clk = ~clk;

    misaligned_splitter #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .multi(multi), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected cycle list for a size and low address bits.
    task automatic plan_expect(input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'd0) begin
            exp_n = 1; exp_off[0] = 0; exp_sz[0] = 2'd0;
        end else if (sz == 2'd1) begin
            if (lo[0]) begin
                exp_n = 2; exp_off[0] = 0; exp_sz[0] = 2'd0; exp_off[1] = 1; exp_sz[1] = 2'd0;
            end else begin
                exp_n = 1; exp_off[0] = 0; exp_sz[0] = 2'd1;
            end
        end else if (lo[0]) begin
            exp_n = 3;
            exp_off[0] = 0; exp_sz[0] = 2'd0;
            exp_off[1] = 1; exp_sz[1] = 2'd1;
            exp_off[2] = 3; exp_sz[2] = 2'd0;
        end else if (lo[1]) begin
            exp_n = 2; exp_off[0] = 0; exp_sz[0] = 2'd1; exp_off[1] = 2; exp_sz[1] = 2'd1;
        end else begin
            exp_n = 1; exp_off[0] = 0; exp_sz[0] = 2'd2;
        end
    endtask

    function automatic string seq_tag(input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'd0) return "R5";
        if (sz == 2'd1) return lo[0] ? "R2" : "R1";
        if (lo[0]) return "R3";
        return lo[1] ? "R4" : "R1";
    endfunction

    // Bus responder: random wait states, lane-positioned reads, byte-enabled writes.
    initial begin
        bus_ack   = 1'b0;
        bus_rdata = '0;
        forever begin
            @(negedge clk);
            bus_ack = 1'b0;
            if (rst_n && bus_valid) begin
                check(req_ready == 1'b0, "R10", "req_ready during cycle", 32'(req_ready), 32'd0);
                check(multi == exp_multi, "R8", "multi during cycle", 32'(multi), 32'(exp_multi));
                if (($urandom % 4) != 0) begin
                    bus_ack = 1'b1;
                    for (int l = 0; l < 4; l++) begin
                        bus_rdata[8*l +: 8] = mem[{bus_addr[5:2], 2'(l)}];
                        if (bus_write && bus_be[l])
                            mem[{bus_addr[5:2], 2'(l)}] = bus_wdata[8*l +: 8];
                    end
                    if (obs_cnt < 4) begin
                        obs_addr[obs_cnt] = bus_addr;
                        obs_sz[obs_cnt]   = bus_size;
                    end
                    obs_cnt++;
                end else begin
                    bus_rdata = $urandom;
                end
            end else if (rst_n) begin
                check(multi == 1'b0, "R8", "multi while idle", 32'(multi), 32'd0);
            end
        end
    end

    task automatic run_op(input bit wr, input logic [1:0] sz, input int a, input logic [31:0] wd);
        int nb;
        string tag;
        logic [31:0] exp_rd;
        nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        tag = seq_tag(sz, 2'(a));
        plan_expect(sz, 2'(a));
        exp_multi = (exp_n > 1);
        obs_cnt   = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = AW'(a); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_wdata = $urandom; req_addr = $urandom;
        forever begin
            if (!wr && rd_valid) break;
            if (wr && req_ready) break;
            if (wr) check(rd_valid == 1'b0, "R9", "rd_valid on write", 32'(rd_valid), 32'd0);
            @(negedge clk);
        end
        check(obs_cnt == exp_n, tag, "cycle count", 32'(obs_cnt), 32'(exp_n));
        for (int i = 0; i < exp_n && i < obs_cnt; i++) begin
            check(obs_addr[i] == AW'(a + exp_off[i]), tag, "cycle address",
                  obs_addr[i], 32'(a + exp_off[i]));
            check(obs_sz[i] == exp_sz[i], tag, "cycle size", 32'(obs_sz[i]), 32'(exp_sz[i]));
        end
        if (wr) begin
            for (int i = 0; i < nb; i++) refm[a + i] = wd[8*i +: 8];
            for (int i = 0; i < 64; i++)
                check(mem[i] == refm[i], "R7", "memory byte after write", 32'(mem[i]), 32'(refm[i]));
        end else begin
            exp_rd = '0;
            for (int i = 0; i < nb; i++) exp_rd[8*i +: 8] = refm[a + i];
            check(rd_data == exp_rd, "R6", "read data", rd_data, exp_rd);
            @(negedge clk);
            check(rd_valid == 1'b0, "R9", "rd_valid width", 32'(rd_valid), 32'd0);
        end
        exp_multi = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) begin
            mem[i]  = 8'($urandom);
            refm[i] = mem[i];
        end
        obs_cnt = 0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
        req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11", "req_ready after reset", 32'(req_ready), 32'd1);
        check(bus_valid == 1'b0, "R11", "bus_valid after reset", 32'(bus_valid), 32'd0);
        check(multi == 1'b0, "R11", "multi after reset", 32'(multi), 32'd0);
        check(rd_valid == 1'b0, "R11", "rd_valid after reset", 32'(rd_valid), 32'd0);

        // Directed: each size at each offset, read then write then read back.
        for (int s = 0; s < 3; s++) begin
            for (int o = 0; o < 4; o++) begin
                run_op(1'b0, 2'(s), 16 + o, 32'h0);
                run_op(1'b1, 2'(s), 16 + o, $urandom);
                run_op(1'b0, 2'(s), 16 + o, 32'h0);
            end
        end
        // Directed: odd word straddling a word boundary at address 3.
        run_op(1'b1, 2'd2, 3, 32'hA1B2C3D4);
        run_op(1'b0, 2'd2, 3, 32'h0);

        // Random mix.
        for (int k = 0; k < 400; k++) begin
            run_op(1'($urandom), 2'($urandom % 3), int'($urandom % 60), $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule